// File: doc/BRIEF.md
# Rectifying Partial-Sum Sparse Packer

This block sits behind the converters of a partitioned in-memory convolution array. It takes one signed partial sum at a time, tagged with the crossbar segment that produced it and the output channel it belongs to. It clamps every negative result to zero and records, per segment, whether a nonzero value survived. When the last segment of a channel arrives, it emits one packed group. The group holds a segment bitmask, the count of surviving values, and those values compacted into the low slots of a value vector. Zero partial sums take no value storage, so the downstream accumulator only needs to walk the populated slots.

The group size is the number of segments a channel is split into. It is derived from the unrolled input dimension and the crossbar row count. Inputs use a valid/ready handshake, and the same handshake form is used on the output. Segments of a channel are expected in ascending order, starting at 0.

Top module: `psum_packer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A value with its sign bit set (bit VAL_W-1, two's complement) is rectified to zero. It sets no mask bit and takes no value slot.
- R3: Bit i of `out_mask` is 1 exactly when segment i of the group had a nonzero rectified value.
- R4: Surviving values are packed in ascending segment order. Slot k sits at `out_vals[k*VAL_W +: VAL_W]`, slot 0 holds the lowest nonzero segment, and every slot at or above `out_count` is zero.
- R5: `out_count` equals the number of ones in `out_mask`.
- R6: A group is emitted when segment SEGS-1 is accepted. `out_valid` is 1 from the next clock edge, and `out_chan` carries the channel index given with that last segment.
- R7: A group whose values all rectify to zero is still emitted, with mask 0 and count 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all output fields hold their values.
- R9: Every group is delivered exactly once. No group is dropped, repeated or overwritten, and no output appears without input.
- R10: A converter result of exactly zero is treated the same as a rectified negative value: no mask bit and no slot.
- R11: The group size SEGS equals ceil(IN_DIM / ROWS). With the defaults IN_DIM=64 and ROWS=8, this is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input partial sum present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_value | input | VAL_W | Signed converter result (two's complement) |
| in_seg | input | SEG_W | Segment index of the value |
| in_chan | input | CH_W | Output-channel index of the value |
| out_valid | output | 1 | Packed group present |
| out_ready | input | 1 | Consumer takes the group this cycle |
| out_mask | output | SEGS | Nonzero bitmask, bit i = segment i |
| out_count | output | CNT_W | Number of packed values |
| out_vals | output | SEGS*VAL_W | Compacted nonzero values, slot 0 lowest |
| out_chan | output | CH_W | Channel of the group |

## Verification
Acceptance is combinational on `in_ready`, so a value counts as taken at the clock edge where both valid and ready are high. The group it completes is visible from the edge after that, which is one register stage. The bench drives inputs and `out_ready` at the falling edge, lets them settle, then reads the outputs before the next rising edge. At each falling edge it checks that `out_valid` is present exactly one cycle after a last segment was taken. During a stall it checks that the fields did not change between two consecutive falling edges. Every delivered group is compared with a mask, count and packing that the bench computes arithmetically from its own value formula.

// File: rtl/psum_pkg.sv
package psum_pkg;

  // Segments per output channel: unrolled input length over crossbar rows, rounded up.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Zero-clamp of a two's-complement value whose sign bit is bit w-1.
  function automatic logic [31:0] relu_fn(input logic [31:0] v, input int w);
    return v[w-1] ? 32'd0 : v;
  endfunction

endpackage

// File: rtl/psum_rectify.sv
module psum_rectify #(
  parameter int VAL_W = 4
) (
  input  logic [VAL_W-1:0] raw_val,
  output logic [VAL_W-1:0] rect_val,
  output logic             rect_nz
);
  import psum_pkg::*;

  assign rect_val = VAL_W'(relu_fn(32'(raw_val), VAL_W));
  assign rect_nz  = |rect_val;

  // R2
  always_comb begin
    if (raw_val[VAL_W-1]) begin
      neg_clamp_chk: assert (!rect_nz);
    end
  end

endmodule

// File: rtl/psum_gather.sv
module psum_gather #(
  parameter int VAL_W = 4,
  parameter int SEGS  = 8,
  parameter int SEG_W = 3,
  parameter int CNT_W = 4,
  parameter int CH_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  logic [VAL_W-1:0]      rect_val,
  input  logic                  rect_nz,
  input  logic [SEG_W-1:0]      seg,
  input  logic [CH_W-1:0]       chan,
  output logic                  grp_done,
  output logic [SEGS-1:0]       grp_mask,
  output logic [SEGS*VAL_W-1:0] grp_vals,
  output logic [CNT_W-1:0]      grp_cnt,
  output logic [CH_W-1:0]       grp_chan
);
  localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(SEGS - 1);

  logic [SEGS-1:0]       mask_q, mask_n;
  logic [SEGS*VAL_W-1:0] vals_q, vals_n;
  logic [CNT_W-1:0]      cnt_q,  cnt_n;
  logic                  seg_last;
  logic                  take_nz;

  assign seg_last = (seg == LAST_SEG);
  assign take_nz  = acc && rect_nz && (int'(cnt_q) < SEGS);

  always_comb begin
    mask_n = mask_q;
    vals_n = vals_q;
    cnt_n  = cnt_q;
    if (take_nz) begin
      mask_n[seg] = 1'b1;
      vals_n[int'(cnt_q)*VAL_W +: VAL_W] = rect_val;
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  assign grp_done = acc && seg_last;
  assign grp_mask = mask_n;
  assign grp_vals = vals_n;
  assign grp_cnt  = cnt_n;
  assign grp_chan = chan;

  always_ff @(posedge clk) begin
    if (!rst_n || grp_done) begin
      mask_q <= '0;
      vals_q <= '0;
      cnt_q  <= '0;
    end else if (acc) begin
      mask_q <= mask_n;
      vals_q <= vals_n;
      cnt_q  <= cnt_n;
    end
  end

  // R2 R10
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rect_nz && !seg_last) |=> $stable(cnt_q));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SEGS);

endmodule

// File: rtl/psum_outreg.sv
module psum_outreg #(
  parameter int VAL_W = 4,
  parameter int SEGS  = 8,
  parameter int CNT_W = 4,
  parameter int CH_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grp_done,
  input  logic [SEGS-1:0]       grp_mask,
  input  logic [SEGS*VAL_W-1:0] grp_vals,
  input  logic [CNT_W-1:0]      grp_cnt,
  input  logic [CH_W-1:0]       grp_chan,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [SEGS-1:0]       out_mask,
  output logic [SEGS*VAL_W-1:0] out_vals,
  output logic [CNT_W-1:0]      out_count,
  output logic [CH_W-1:0]       out_chan,
  output logic                  stall
);
  assign stall = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_vals  <= '0;
      out_count <= '0;
      out_chan  <= '0;
    end else if (grp_done) begin
      out_valid <= 1'b1;
      out_mask  <= grp_mask;
      out_vals  <= grp_vals;
      out_count <= grp_cnt;
      out_chan  <= grp_chan;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> !stall);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (out_valid && $stable(out_mask) && $stable(out_vals)
               && $stable(out_count) && $stable(out_chan)));

  // R5
  count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_count) == $countones(out_mask)));

  // R4
  tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_vals >> (int'(out_count) * VAL_W)) == '0));

endmodule

// File: rtl/psum_packer.sv
module psum_packer
  import psum_pkg::*;
#(
  parameter int IN_DIM = 64,
  parameter int ROWS   = 8,
  parameter int VAL_W  = 4,
  parameter int CH_W   = 4,
  localparam int SEGS  = ceil_div(IN_DIM, ROWS),
  localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1,
  localparam int CNT_W = $clog2(SEGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [VAL_W-1:0]      in_value,
  input  logic [SEG_W-1:0]      in_seg,
  input  logic [CH_W-1:0]       in_chan,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SEGS-1:0]       out_mask,
  output logic [CNT_W-1:0]      out_count,
  output logic [SEGS*VAL_W-1:0] out_vals,
  output logic [CH_W-1:0]       out_chan
);
  logic [VAL_W-1:0]      rect_val;
  logic                  rect_nz;
  logic                  acc;
  logic                  stall;
  logic                  grp_done;
  logic [SEGS-1:0]       grp_mask;
  logic [SEGS*VAL_W-1:0] grp_vals;
  logic [CNT_W-1:0]      grp_cnt;
  logic [CH_W-1:0]       grp_chan;

  assign in_ready = !stall;
  assign acc      = in_valid && in_ready;

  psum_rectify #(.VAL_W(VAL_W)) u_rect (
    .raw_val  (in_value),
    .rect_val (rect_val),
    .rect_nz  (rect_nz)
  );

  psum_gather #(
    .VAL_W(VAL_W), .SEGS(SEGS), .SEG_W(SEG_W), .CNT_W(CNT_W), .CH_W(CH_W)
  ) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .rect_val (rect_val),
    .rect_nz  (rect_nz),
    .seg      (in_seg),
    .chan     (in_chan),
    .grp_done (grp_done),
    .grp_mask (grp_mask),
    .grp_vals (grp_vals),
    .grp_cnt  (grp_cnt),
    .grp_chan (grp_chan)
  );

  psum_outreg #(
    .VAL_W(VAL_W), .SEGS(SEGS), .CNT_W(CNT_W), .CH_W(CH_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_done  (grp_done),
    .grp_mask  (grp_mask),
    .grp_vals  (grp_vals),
    .grp_cnt   (grp_cnt),
    .grp_chan  (grp_chan),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .out_vals  (out_vals),
    .out_count (out_count),
    .out_chan  (out_chan),
    .stall     (stall)
  );

  // R6 R11
  emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_seg == SEG_W'(SEGS - 1))) |=> out_valid);

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc));

endmodule

// File: tb/test_psum_packer.sv
module test_psum_packer;
  localparam int SEGS  = (64 + 8 - 1) / 8;   // R11: ceil(IN_DIM/ROWS)
  localparam int VAL_W = 4;
  localparam int CH_W  = 4;
  localparam int SEG_W = 3;
  localparam int CNT_W = 4;
  localparam int NG    = 40;
  localparam int LIMIT = 20000;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [VAL_W-1:0]      in_value = '0;
  logic [SEG_W-1:0]      in_seg = '0;
  logic [CH_W-1:0]       in_chan = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b0;
  logic [SEGS-1:0]       out_mask;
  logic [CNT_W-1:0]      out_count;
  logic [SEGS*VAL_W-1:0] out_vals;
  logic [CH_W-1:0]       out_chan;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  psum_packer #(.IN_DIM(64), .ROWS(8), .VAL_W(VAL_W), .CH_W(CH_W)) i_psum_packer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_value(in_value),
    .in_seg(in_seg), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
    .out_count(out_count), .out_vals(out_vals), .out_chan(out_chan)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gval(input int g, input int s);
    case (g)
      0: return 4'd0;
      1: return 4'(8 + (s % 8));
      2: return 4'(1 + (s % 7));
      3: return (s % 2 == 1) ? 4'(s) : 4'(15 - s);
      default: return 4'((g * 5 + s * 11 + g * s) % 16);
    endcase
  endfunction

  function automatic void expect_grp(input int g, output logic [SEGS-1:0] m,
                                     output int c, output logic [SEGS*VAL_W-1:0] v);
    m = '0; c = 0; v = '0;
    for (int s = 0; s < SEGS; s++) begin
      logic [3:0] x;
      x = gval(g, s);
      if (x < 4'd8 && x != 4'd0) begin
        m[s] = 1'b1;
        v[c*VAL_W +: VAL_W] = x;
        c++;
      end
    end
  endfunction

  initial begin
    int cyc = 0, gs = 0, ss = 0, grecv = 0;
    bit exp_new = 0, stalled = 0;
    logic [SEGS-1:0] hm; logic [SEGS*VAL_W-1:0] hv; logic [CNT_W-1:0] hc; logic [CH_W-1:0] hch;
    logic [SEGS-1:0] em; int ec; logic [SEGS*VAL_W-1:0] ev;

    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    while (grecv < NG && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      out_ready = (gs >= 10) ? ((cyc % 5) < 3) : 1'b1;
      in_valid  = (gs < NG) && ((cyc % 7) != 3);
      in_value  = gval(gs, ss);
      in_seg    = SEG_W'(ss);
      in_chan   = CH_W'(gs % 16);
      #1;
      if (exp_new) chk(out_valid == 1'b1, "R6 R11 valid one edge after last segment", out_valid, 1);
      exp_new = 0;
      if (stalled) begin
        chk(out_valid == 1'b1 && out_mask == hm && out_vals == hv && out_count == hc
            && out_chan == hch, "R8 fields held during stall", out_vals, hv);
      end
      stalled = 0;
      if (out_valid && !out_ready) begin
        chk(in_ready == 1'b0, "R8 in_ready low while stalled", in_ready, 0);
        hm = out_mask; hv = out_vals; hc = out_count; hch = out_chan;
        stalled = 1;
      end
      if (out_valid && out_ready) begin
        expect_grp(grecv, em, ec, ev);
        chk(out_mask == em, "R3 mask", out_mask, em);
        chk(out_vals == ev, "R4 packed values", out_vals, ev);
        chk(int'(out_count) == ec, "R5 count", out_count, ec);
        chk(out_chan == CH_W'(grecv % 16), "R6 channel", out_chan, grecv % 16);
        if (grecv == 0) begin
          chk(out_mask == '0 && out_count == '0, "R7 all-zero group emitted empty", out_mask, 0);
          chk(out_vals == '0, "R10 zero input takes no slot", out_vals, 0);
        end
        if (grecv == 1)
          chk(out_mask == '0 && out_count == '0, "R2 negatives clamped", out_count, 0);
        grecv++;
      end
      if (in_valid && in_ready) begin
        if (ss == SEGS - 1) begin
          exp_new = 1; ss = 0; gs++;
        end else begin
          ss++;
        end
      end
    end
    if (cyc >= LIMIT) chk(1'b0, "R9 watchdog expired", grecv, NG);

    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R9 no extra group", out_valid, 0);
    end
    chk(grecv == NG, "R9 groups delivered once each", grecv, NG);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule